// File: doc/BRIEF.md
# Programmable I2S Sample Delay Line

This block time-aligns one loudspeaker driver against another by holding back an I2S stereo stream by a programmable amount of time. Serial data, bit clock and word clock arrive on the system clock domain (the bit clock is an oversampled level, synchronous to `clk_i`). The block collects each stereo frame into a circular frame store, picks an older frame as the output source, and shifts it back out on the same bit and word clocks. The downstream converter therefore keeps the incoming bit clock and word clock, and only the data line is replaced. Both the delayed and the undelayed paths must run from the same master clock if they are to stay aligned.

The delay is given in microseconds. An external 4-bit sample-rate code selects the frame rate, and the block converts the time into a whole number of frames: frames = round(delay_us × Fs / 1e6), limited to DEPTH−1. Because the tap is recomputed for every rate code, the acoustic delay stays constant from 22.05 kHz up to 384 kHz. Samples are never altered: there is no filtering, resampling or gain change. A delay of zero leaves one frame of pipeline latency. Whenever the tap changes, the output sends silence until the store holds enough frames for the new tap. DEPTH must be a power of two.

Top module: `i2s_delay_line`

## Requirements
- R1: Output words are bit-exact copies of input words, and the left and right words of a stereo frame are delayed by the same number of frames.
- R2: The tap in frames is round(delay_us_i × Fs / 1e6), where rate_code_i selects Fs: 0=22.05k, 1=24k, 2=44.1k, 3=48k, 4=88.2k, 5=96k, 6=176.4k, 7=192k, 8=352.8k, 9=384k Hz. The tap is limited to DEPTH−1.
- R3: A rate_code_i value from 10 to 15 gives a tap of zero frames, one clock after it is applied.
- R4: With a tap of zero, input frame n is sent during the word slots of input frame n+1 (one frame of latency).
- R5: After reset, and after any change of the tap, every output frame whose source frame was received before that event is all zeros. Valid data resumes once the store has refilled to the new tap.
- R6: Settings are applied only when a frame completes. A settings change that leaves the tap unchanged does not interrupt the output.
- R7: The framing is I2S with WORD_W bits per channel slot. Word clock low carries left and high carries right. The MSB comes one bit clock after the word-clock transition. sdata_o changes only in response to a bit-clock rising edge, follows the input slot alignment, and is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; oversamples the I2S lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | I2S bit clock level, data sampled on its rising edge |
| lrclk_i | input | 1 | I2S word clock, low = left |
| sdata_i | input | 1 | I2S serial data in |
| delay_us_i | input | US_W | Requested delay in microseconds |
| rate_code_i | input | 4 | Sample-rate code (0..9 valid) |
| sdata_o | output | 1 | Delayed I2S serial data, aligned to bclk_i/lrclk_i |

## Verification
The assertions check on every cycle that the data line moves only after a bit-clock rising edge and starts each word with the MSB of the selected frame. They also check that the active tap switches only at a frame boundary, that a tap change blanks the output, that a zero tap forwards the frame just captured, and that an invalid rate code forces a zero tap. Only the bench scenarios can show the end-to-end behaviour. These include the exact frame count for each rate code at a given delay, the length of the silent refill after a change, and bit-exact transport of both channels over many frames. They also include the case where a changed setting rounds to the same tap and the stream carries on without a break.

// File: rtl/i2s_delay_pkg.sv
package i2s_delay_pkg;
  localparam int unsigned FS_UNIT_HZ = 50;
  localparam int unsigned FS_W       = 13;
  localparam int unsigned NUM_RATES  = 10;

  // sample rate in units of FS_UNIT_HZ, zero for unused codes
  function automatic logic [FS_W-1:0] fs_units(input logic [3:0] code);
    case (code)
      4'd0:    return FS_W'(441);
      4'd1:    return FS_W'(480);
      4'd2:    return FS_W'(882);
      4'd3:    return FS_W'(960);
      4'd4:    return FS_W'(1764);
      4'd5:    return FS_W'(1920);
      4'd6:    return FS_W'(3528);
      4'd7:    return FS_W'(3840);
      4'd8:    return FS_W'(7056);
      4'd9:    return FS_W'(7680);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/i2s_delay_tap_calc.sv
module i2s_delay_tap_calc
  import i2s_delay_pkg::*;
#(
  parameter int unsigned US_W  = 8,
  parameter int unsigned DEPTH = 128,
  localparam int unsigned TAP_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [US_W-1:0]   delay_us_i,
  input  logic [3:0]        rate_code_i,
  output logic [TAP_W-1:0]  tap_o
);
  localparam int unsigned PROD_W = US_W + FS_W + 1;
  localparam int unsigned SCALE  = 1000000 / FS_UNIT_HZ;

  logic [PROD_W-1:0] prod, frames;
  logic [TAP_W-1:0]  tap_d;

  always_comb begin
    prod   = PROD_W'(delay_us_i) * PROD_W'(fs_units(rate_code_i));
    frames = (prod + PROD_W'(SCALE / 2)) / PROD_W'(SCALE);
    tap_d  = (frames > PROD_W'(DEPTH - 1)) ? TAP_W'(DEPTH - 1) : frames[TAP_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_o <= '0;
    else         tap_o <= tap_d;
  end

  p_bad_code_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_code_i > 4'(NUM_RATES - 1)) |=> (tap_o == '0));
endmodule

// File: rtl/i2s_delay_rx.sv
module i2s_delay_rx #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned FRAME_W = 2 * WORD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bclk_i,
  input  logic               lrclk_i,
  input  logic               sdata_i,
  output logic               bit_rise_o,
  output logic               word_start_o,
  output logic               lr_o,
  output logic               frame_ev_o,
  output logic [FRAME_W-1:0] frame_o
);
  logic bclk_q, bclk_q2, lr_q, sd_q, lr_prev;
  logic [FRAME_W-1:0] shreg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q  <= 1'b0;
      bclk_q2 <= 1'b0;
      lr_q    <= 1'b0;
      sd_q    <= 1'b0;
    end else begin
      bclk_q  <= bclk_i;
      bclk_q2 <= bclk_q;
      lr_q    <= lrclk_i;
      sd_q    <= sdata_i;
    end
  end

  assign bit_rise_o   = bclk_q & ~bclk_q2;
  // the bit taken at a word-clock change is the LSB of the previous word
  assign word_start_o = bit_rise_o & (lr_q != lr_prev);
  assign frame_ev_o   = word_start_o & ~lr_q;
  assign lr_o         = lr_q;
  assign frame_o      = {shreg[FRAME_W-2:0], sd_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg   <= '0;
      lr_prev <= 1'b0;
    end else if (bit_rise_o) begin
      shreg   <= frame_o;
      lr_prev <= lr_q;
    end
  end

  p_single_frame_ev_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ev_o |=> !frame_ev_o);
endmodule

// File: rtl/i2s_delay_store.sv
module i2s_delay_store #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 128,
  localparam int unsigned FRAME_W = 2 * WORD_W,
  localparam int unsigned TAP_W   = $clog2(DEPTH),
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_ev_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [TAP_W-1:0]   tap_i,
  output logic [FRAME_W-1:0] rd_frame_o
);
  logic [FRAME_W-1:0] mem [DEPTH];
  logic [TAP_W-1:0]   wp, tap_cur, rd_idx;
  logic [CNT_W-1:0]   cnt, cnt_base, cnt_nxt;
  logic               tap_chg, filled;
  logic [FRAME_W-1:0] src;

  always_comb begin
    tap_chg  = (tap_i != tap_cur);
    cnt_base = tap_chg ? '0 : cnt;
    cnt_nxt  = (cnt_base == CNT_W'(DEPTH)) ? cnt_base : cnt_base + 1'b1;
    rd_idx   = wp - tap_i;
    src      = (tap_i == '0) ? frame_i : mem[rd_idx];
    // source frame must have been written since the last tap change
    filled   = CNT_W'(tap_i) < cnt_nxt;
    rd_frame_o = filled ? src : '0;
  end

  always_ff @(posedge clk_i) begin
    if (frame_ev_i) mem[wp] <= frame_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp      <= '0;
      tap_cur <= '0;
      cnt     <= '0;
    end else if (frame_ev_i) begin
      wp      <= wp + 1'b1;
      tap_cur <= tap_i;
      cnt     <= cnt_nxt;
    end
  end

  p_refill_mute_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_ev_i && tap_i != tap_cur && tap_i != '0) |-> (rd_frame_o == '0));
  p_zero_tap_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_ev_i && tap_i == '0) |-> (rd_frame_o == frame_i));
  p_tap_at_frame_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_ev_i |=> $stable(tap_cur));
  p_fill_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/i2s_delay_tx.sv
module i2s_delay_tx #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned FRAME_W = 2 * WORD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_rise_i,
  input  logic               word_start_i,
  input  logic               lr_i,
  input  logic               frame_ev_i,
  input  logic [FRAME_W-1:0] rd_frame_i,
  output logic               sdata_o
);
  logic [WORD_W-1:0] out_r, sr, load_word;

  assign load_word = lr_i ? out_r : rd_frame_i[FRAME_W-1 -: WORD_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_r   <= '0;
      sr      <= '0;
      sdata_o <= 1'b0;
    end else begin
      if (frame_ev_i) out_r <= rd_frame_i[WORD_W-1:0];
      if (bit_rise_i) begin
        if (word_start_i) begin
          sdata_o <= load_word[WORD_W-1];
          sr      <= {load_word[WORD_W-2:0], 1'b0};
        end else begin
          sdata_o <= sr[WORD_W-1];
          sr      <= {sr[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  p_out_on_bit_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_rise_i |=> $stable(sdata_o));
  p_left_msb_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_start_i && !lr_i) |=> (sdata_o == $past(rd_frame_i[FRAME_W-1])));
endmodule

// File: rtl/i2s_delay_line.sv
module i2s_delay_line #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned US_W   = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bclk_i,
  input  logic            lrclk_i,
  input  logic            sdata_i,
  input  logic [US_W-1:0] delay_us_i,
  input  logic [3:0]      rate_code_i,
  output logic            sdata_o
);
  localparam int unsigned FRAME_W = 2 * WORD_W;
  localparam int unsigned TAP_W   = $clog2(DEPTH);

  logic               bit_rise, word_start, lr, frame_ev;
  logic [FRAME_W-1:0] frame, rd_frame;
  logic [TAP_W-1:0]   tap;

  i2s_delay_tap_calc #(.US_W(US_W), .DEPTH(DEPTH)) u_tap (
    .clk_i, .rst_ni, .delay_us_i, .rate_code_i, .tap_o(tap)
  );

  i2s_delay_rx #(.WORD_W(WORD_W)) u_rx (
    .clk_i, .rst_ni, .bclk_i, .lrclk_i, .sdata_i,
    .bit_rise_o(bit_rise), .word_start_o(word_start), .lr_o(lr),
    .frame_ev_o(frame_ev), .frame_o(frame)
  );

  i2s_delay_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .frame_ev_i(frame_ev), .frame_i(frame),
    .tap_i(tap), .rd_frame_o(rd_frame)
  );

  i2s_delay_tx #(.WORD_W(WORD_W)) u_tx (
    .clk_i, .rst_ni, .bit_rise_i(bit_rise), .word_start_i(word_start),
    .lr_i(lr), .frame_ev_i(frame_ev), .rd_frame_i(rd_frame), .sdata_o
  );
endmodule

// File: tb/i2s_delay_line_test.sv
module i2s_delay_line_test;
  localparam int W     = 16;
  localparam int FW    = 2 * W;
  localparam int DEPTH = 128;
  localparam int US_W  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [US_W-1:0] delay_us = '0;
  logic [3:0] rate_code = 4'd2;
  logic sdata_o;

  always #5 clk = ~clk;

  i2s_delay_line #(.WORD_W(W), .DEPTH(DEPTH), .US_W(US_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .lrclk_i(lrclk),
    .sdata_i(sdata), .delay_us_i(delay_us), .rate_code_i(rate_code),
    .sdata_o(sdata_o)
  );

  int checks = 0, failures = 0;
  int fidx = 0, mtap = 0, mcnt = 0, pat = 0;
  logic [FW-1:0] hist [1024];
  logic [FW-1:0] exp_cur = '0;
  logic exp_muted = 1'b1;
  string cur_tag = "R4";

  function automatic int model_tap(int us, int code);
    int fs, t;
    case (code)
      0: fs = 22050;  1: fs = 24000;  2: fs = 44100;  3: fs = 48000;
      4: fs = 88200;  5: fs = 96000;  6: fs = 176400; 7: fs = 192000;
      8: fs = 352800; 9: fs = 384000; default: fs = 0;
    endcase
    t = (us * fs + 500000) / 1000000;
    if (t > DEPTH - 1) t = DEPTH - 1;
    return t;
  endfunction

  function automatic logic [FW-1:0] gen(int f, int mode);
    if (mode == 1)
      return {W'(1) << (f % W), W'(1) << (W - 1 - (f % W))};
    return {W'(f * 40503 + 23130), W'((f * 7919) ^ 43690)};
  endfunction

  task automatic check(string tag, logic [FW-1:0] act, logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s frame=%0d actual=%h expected=%h", tag, fidx, act, exp);
    end
  endtask

  task automatic drive_frame(input logic [FW-1:0] fr, output logic [FW-1:0] got);
    for (int p = 0; p < FW; p++) begin
      @(negedge clk);
      bclk  = 1'b0;
      sdata = fr[FW-1-p];
      lrclk = 1'(((p + 1) / W) % 2);
      repeat (2) @(negedge clk);
      got[FW-1-p] = sdata_o;
      bclk = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic run_frames(int n);
    logic [FW-1:0] fr, got;
    int t;
    for (int k = 0; k < n; k++) begin
      fr = gen(fidx, pat);
      hist[fidx] = fr;
      drive_frame(fr, got);
      check(exp_muted ? "R5" : cur_tag, got, exp_cur);
      t = model_tap(int'(delay_us), int'(rate_code));
      if (t != mtap) begin mtap = t; mcnt = 0; end
      if (mcnt < DEPTH) mcnt++;
      exp_muted = !(t < mcnt);
      exp_cur   = exp_muted ? '0 : hist[fidx - t];
      fidx++;
    end
  endtask

  task automatic set_cfg(int code, int us, string tag);
    rate_code = 4'(code);
    delay_us  = US_W'(us);
    cur_tag   = tag;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R7", {FW{sdata_o}}, '0);

    // R4: zero delay, one frame latency
    set_cfg(2, 0, "R4");
    run_frames(4);
    // R7: walking ones reveal bit order and slot alignment
    pat = 1;
    set_cfg(3, 0, "R7");
    run_frames(17);
    // R1: bit-exact transport through a 9-frame tap at 88.2 kHz
    pat = 0;
    set_cfg(4, 100, "R1");
    run_frames(13);
    // R2: every rate code at 250 us
    for (int c = 0; c < 10; c++) begin
      set_cfg(c, 250, "R2");
      run_frames(model_tap(250, c) + 3);
    end
    set_cfg(9, 2, "R2");
    run_frames(4);
    // R6: 50 -> 51 us at 44.1 kHz both round to 2 frames, no gap
    set_cfg(2, 50, "R6");
    run_frames(5);
    set_cfg(2, 51, "R6");
    run_frames(4);
    set_cfg(2, 57, "R6");
    run_frames(6);
    // R3: unused rate codes give zero delay
    set_cfg(12, 200, "R3");
    run_frames(4);
    set_cfg(15, 255, "R3");
    run_frames(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule